// File: doc/BRIEF.md
# Dual-enable watchdog with timebase

This block is a system watchdog built around a free-running timebase counter. Software arms it through two control/status words, each holding one enable bit, and keeps it alive by writing a one to the timeout flag. This write is the kick. It clears the flag and restarts the timeout interval. The block runs while either enable bit is set, so both bits must be cleared to stop it. When the optional lock is built in, the watchdog cannot be stopped once it has started.

The timeout has two stages. When the first interval of 2^INTERVAL_LOG2 cycles runs out, the block sets the timeout flag and raises an interrupt. If a second interval runs out before software kicks, the block drives a reset request for PULSE_CYCLES cycles. It also records the cause in a sticky reset-status flag, and only the power-on reset clears that flag. At the end of the pulse the block returns to its disabled state, just as the rest of the system does.

The timeout is handled by a four-state machine:

- **IDLE**: both enables are clear.
- **ARMED**: the watchdog is counting and the flag is clear.
- **WARNED**: the flag is set and the interrupt is raised.
- **RESETTING**: the reset request is being driven.

The transitions are:

- **IDLE→ARMED**: either enable bit becomes set.
- **ARMED→WARNED**: the interval expires.
- **WARNED→ARMED**: software kicks.
- **WARNED→RESETTING**: the interval expires a second time.
- **ARMED/WARNED→IDLE**: both enable bits are cleared.
- **RESETTING→IDLE**: the pulse ends.

In ARMED and WARNED, a kick takes priority over an expiry in the same cycle.

Top module: `wdog_timebase`

## Requirements
- R1: After power-on reset, word 0x0 and word 0x4 read zero, and both `wdt_irq` and `reset_req` are low.
- R2: Address 0x8 reads the timebase counter. It advances by one every clock and wraps modulo 2^TB_W, whether or not the watchdog is enabled.
- R3: A kick is a write to 0x0 with bit 2 set. If either enable bit is set after that write, the kick clears the timebase to zero. While the block stays disabled, the same write leaves the counter running and sets no flag.
- R4: Exactly 2^INTERVAL_LOG2 cycles after a kick, if no further kick arrives, the block sets the timeout flag (bit 2 of 0x0) and raises `wdt_irq`.
- R5: Writing 1 to bit 2 of 0x0 clears the timeout flag and drops `wdt_irq` on the next cycle. Writing 0 to bit 2 leaves the flag set.
- R6: If no kick arrives, `reset_req` rises 2^(INTERVAL_LOG2+1) cycles after the last kick and stays high for exactly PULSE_CYCLES cycles. The reset-status flag (bit 3 of 0x0) is set at the same moment. `wdt_irq` is low while `reset_req` is high.
- R7: After the pulse, both enable bits and the timeout flag read zero and the reset-status flag stays set. Writing 0 to bit 3 keeps it. Writing 1 to bit 3 clears it.
- R8: Enable A is bit 1 of 0x0 and enable B is bit 0 of 0x4. The block keeps timing while either one is set. Once both are cleared, it raises neither output.
- R9: With LOCK_ON_ENABLE set, writes that would clear an enable bit are ignored once the watchdog has been enabled, so the timeout still leads to the interrupt and the reset pulse.
- R10: Bit 0 of 0x0 always reads zero. Writes to 0x8 do not change the counter. Unmapped addresses read zero.
- R11: Writing 0xE to 0x0 and then 1 to 0x4 starts the watchdog with both the timeout flag and the reset-status flag cleared, so 0x0 reads 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 4 | Write data; only the control bits exist |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| wdt_irq | output | 1 | High while the timeout flag is set |
| reset_req | output | 1 | System reset request pulse |

## Verification
The timebase is sampled at gaps of 1 to 20 cycles and across a wrap. This separates a counter that really runs free from one that stalls, skips or is reset by stray writes.

The kick-to-timeout path is swept over 13 kick offsets. The interrupt, reset-request and pulse-length cycle counts must not change with the offset, which exposes an off-by-one error or an interval that is not restarted by the kick.

A further pattern clears only one enable bit, then both. It is applied to an unlocked instance and a locked instance in parallel, which tells the dual-enable rule apart from the enable-once lock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_IDLE      = 2'd0,
        WD_ARMED     = 2'd1,
        WD_WARNED    = 2'd2,
        WD_RESETTING = 2'd3
    } wd_state_e;

    // byte offsets of the register words
    localparam int unsigned OFS_CTRL0 = 0;
    localparam int unsigned OFS_CTRL1 = 4;
    localparam int unsigned OFS_TIME  = 8;

    // control bit positions (software decodes these)
    localparam int unsigned BIT_RSTSTS = 3;
    localparam int unsigned BIT_TOFLAG = 2;
    localparam int unsigned BIT_EN_A   = 1;
    localparam int unsigned BIT_EN_B   = 0;

    localparam int unsigned CTRL_BITS = 4;

endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int unsigned TB_W          = 32,
    parameter int unsigned INTERVAL_LOG2 = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    output logic [TB_W-1:0] count_o,
    output logic            expire_o
);

    logic [TB_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o  = cnt_q;
    // last cycle of each interval: low bits all ones
    assign expire_o = &cnt_q[INTERVAL_LOG2-1:0];

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W         = 32,
    parameter int unsigned ADDR_W         = 4,
    parameter int unsigned TB_W           = 32,
    parameter bit          LOCK_ON_ENABLE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [CTRL_BITS-1:0] bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    input  logic [TB_W-1:0]      count_i,
    input  logic                 flag_i,
    input  logic                 resetting_i,
    input  logic                 set_rst_sts_i,
    input  logic                 clear_enables_i,
    output logic                 en_any_o,
    output logic                 kick_o,
    output logic                 tb_clear_o,
    output logic                 rst_sts_o,
    output logic                 lock_o
);

    localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(OFS_CTRL0);
    localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(OFS_CTRL1);
    localparam logic [ADDR_W-1:0] A_TIME  = ADDR_W'(OFS_TIME);

    logic en_a_q, en_b_q, en_a_d, en_b_d;
    logic rst_sts_q, rst_sts_d;
    logic wr_ctrl0, wr_ctrl1;

    assign wr_ctrl0 = bus_sel_i && bus_wr_i && (bus_addr_i == A_CTRL0);
    assign wr_ctrl1 = bus_sel_i && bus_wr_i && (bus_addr_i == A_CTRL1);

    // enable-once lock, present only when configured
    generate
        if (LOCK_ON_ENABLE) begin : g_lock
            logic lock_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lock_q <= 1'b0;
                end else if (clear_enables_i) begin
                    lock_q <= 1'b0;
                end else if (en_a_q || en_b_q) begin
                    lock_q <= 1'b1;
                end
            end
            assign lock_o = lock_q;
        end else begin : g_nolock
            assign lock_o = 1'b0;
        end
    endgenerate

    always_comb begin
        en_a_d = en_a_q;
        en_b_d = en_b_q;
        if (clear_enables_i) begin
            en_a_d = 1'b0;
            en_b_d = 1'b0;
        end else begin
            if (wr_ctrl0 && (bus_wdata_i[BIT_EN_A] || !lock_o)) begin
                en_a_d = bus_wdata_i[BIT_EN_A];
            end
            if (wr_ctrl1 && (bus_wdata_i[BIT_EN_B] || !lock_o)) begin
                en_b_d = bus_wdata_i[BIT_EN_B];
            end
        end
    end

    always_comb begin
        rst_sts_d = rst_sts_q;
        if (set_rst_sts_i) begin
            rst_sts_d = 1'b1;
        end else if (wr_ctrl0 && bus_wdata_i[BIT_RSTSTS]) begin
            rst_sts_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_a_q    <= 1'b0;
            en_b_q    <= 1'b0;
            rst_sts_q <= 1'b0;
        end else begin
            en_a_q    <= en_a_d;
            en_b_q    <= en_b_d;
            rst_sts_q <= rst_sts_d;
        end
    end

    assign kick_o     = wr_ctrl0 && bus_wdata_i[BIT_TOFLAG] && !resetting_i;
    assign tb_clear_o = kick_o && (en_a_d || en_b_d);
    assign en_any_o   = en_a_q || en_b_q;
    assign rst_sts_o  = rst_sts_q;

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CTRL0: begin
                bus_rdata_o[BIT_RSTSTS] = rst_sts_q;
                bus_rdata_o[BIT_TOFLAG] = flag_i;
                bus_rdata_o[BIT_EN_A]   = en_a_q;
            end
            A_CTRL1: bus_rdata_o[BIT_EN_B] = en_b_q;
            A_TIME:  bus_rdata_o[TB_W-1:0] = count_i;
            default: bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_any_i,
    input  logic kick_i,
    input  logic expire_i,
    output logic irq_o,
    output logic rst_req_o,
    output logic flag_o,
    output logic resetting_o,
    output logic set_rst_sts_o,
    output logic clear_enables_o
);

    localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_CYCLES - 1);

    wd_state_e state_q, state_d;
    logic [PW-1:0] pulse_q;
    logic pulse_done;

    assign pulse_done = (pulse_q == PULSE_LAST);

    // state register and pulse timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            pulse_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WD_RESETTING) begin
                pulse_q <= pulse_q + 1'b1;
            end else begin
                pulse_q <= '0;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (en_any_i) state_d = WD_ARMED;
            end
            WD_ARMED: begin
                if (!en_any_i)     state_d = WD_IDLE;
                else if (kick_i)   state_d = WD_ARMED;
                else if (expire_i) state_d = WD_WARNED;
            end
            WD_WARNED: begin
                if (!en_any_i)     state_d = WD_IDLE;
                else if (kick_i)   state_d = WD_ARMED;
                else if (expire_i) state_d = WD_RESETTING;
            end
            WD_RESETTING: begin
                if (pulse_done) state_d = WD_IDLE;
            end
            default: state_d = WD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_o           = (state_q == WD_WARNED);
        rst_req_o       = (state_q == WD_RESETTING);
        resetting_o     = (state_q == WD_RESETTING);
        flag_o          = (state_q == WD_WARNED) || (state_q == WD_RESETTING);
        set_rst_sts_o   = (state_q == WD_WARNED) && (state_d == WD_RESETTING);
        clear_enables_o = (state_q == WD_RESETTING) && pulse_done;
    end

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W         = 32,
    parameter int unsigned ADDR_W         = 4,
    parameter int unsigned TB_W           = 32,
    parameter int unsigned INTERVAL_LOG2  = 24,
    parameter int unsigned PULSE_CYCLES   = 16,
    parameter bit          LOCK_ON_ENABLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_irq,
    output logic              reset_req
);

    logic [TB_W-1:0] tb_count;
    logic expire, tb_clear, kick, en_any, rst_sts, lock_active;
    logic flag, resetting, set_rst_sts, clear_enables;

    wdt_timebase #(
        .TB_W(TB_W),
        .INTERVAL_LOG2(INTERVAL_LOG2)
    ) u_timebase (
        .clk(clk),
        .rst_n(rst_n),
        .clear_i(tb_clear),
        .count_o(tb_count),
        .expire_o(expire)
    );

    wdt_regs #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .TB_W(TB_W),
        .LOCK_ON_ENABLE(LOCK_ON_ENABLE)
    ) u_regs (
        .clk(clk),
        .rst_n(rst_n),
        .bus_sel_i(bus_sel),
        .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .count_i(tb_count),
        .flag_i(flag),
        .resetting_i(resetting),
        .set_rst_sts_i(set_rst_sts),
        .clear_enables_i(clear_enables),
        .en_any_o(en_any),
        .kick_o(kick),
        .tb_clear_o(tb_clear),
        .rst_sts_o(rst_sts),
        .lock_o(lock_active)
    );

    wdt_fsm #(
        .PULSE_CYCLES(PULSE_CYCLES)
    ) u_fsm (
        .clk(clk),
        .rst_n(rst_n),
        .en_any_i(en_any),
        .kick_i(kick),
        .expire_i(expire),
        .irq_o(wdt_irq),
        .rst_req_o(reset_req),
        .flag_o(flag),
        .resetting_o(resetting),
        .set_rst_sts_o(set_rst_sts),
        .clear_enables_o(clear_enables)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int unsigned PULSE_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic rst_req,
    input logic en_any,
    input logic kick,
    input logic expire,
    input logic rst_sts,
    input logic lock
);

    localparam int unsigned RW = $clog2(PULSE_CYCLES + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (rst_req) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    // R6
    irq_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req));

    // R6
    pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (run_q < RW'(PULSE_CYCLES)));

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (run_q == RW'(PULSE_CYCLES)));

    // R6
    rst_sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> rst_sts);

    // R7
    post_pulse_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> !en_any);

    // R4
    warn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(expire) && $past(en_any)));

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(kick) || rst_req || $past(!en_any)));

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !rst_req) |=> en_any);

endmodule

bind wdog_timebase wdt_checker #(
    .PULSE_CYCLES(PULSE_CYCLES)
) u_wdt_checker (
    .clk(clk),
    .rst_n(rst_n),
    .irq(wdt_irq),
    .rst_req(reset_req),
    .en_any(en_any),
    .kick(kick),
    .expire(expire),
    .rst_sts(rst_sts),
    .lock(lock_active)
);

// File: tb/test_wdog_timebase.sv
module test_wdog_timebase;

    localparam int TBW = 8;
    localparam int NLOG = 4;
    localparam int PULSE = 5;
    localparam int IVL = 1 << NLOG;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0;
    logic bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [3:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_lk;
    logic irq, rst, irq_lk, rst_lk;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    wdog_timebase #(.DATA_W(32), .ADDR_W(4), .TB_W(TBW), .INTERVAL_LOG2(NLOG),
                    .PULSE_CYCLES(PULSE), .LOCK_ON_ENABLE(1'b0)) i_wdog_timebase (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .wdt_irq(irq), .reset_req(rst));

    wdog_timebase #(.DATA_W(32), .ADDR_W(4), .TB_W(TBW), .INTERVAL_LOG2(NLOG),
                    .PULSE_CYCLES(PULSE), .LOCK_ON_ENABLE(1'b1)) i_wdog_timebase_lock (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_lk),
        .wdt_irq(irq_lk), .reset_req(rst_lk));

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; commits at the next posedge
    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // combinational read, no clock edge consumed
    task automatic rd(input logic [3:0] a, output int d, output int dl);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1;
        d = int'(rdata); dl = int'(rdata_lk);
        bus_sel = 1'b0;
    endtask

    task automatic run(input int n, output int fi, output int fr, output int nr,
                       output int fil, output int frl);
        fi = -1; fr = -1; nr = 0; fil = -1; frl = -1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (irq && fi < 0) fi = k;
            if (rst && fr < 0) fr = k;
            if (rst) nr++;
            if (irq_lk && fil < 0) fil = k;
            if (rst_lk && frl < 0) frl = k;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : main
        int v, vl, c0, c1, fi, fr, nr, fil, frl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v, vl); chk("R1 ctrl0", v, 0); chk("R1 ctrl0 lock", vl, 0);
        rd(4'h4, v, vl); chk("R1 ctrl1", v, 0);
        chk("R1 irq", int'(irq), 0); chk("R1 reset_req", int'(rst), 0);

        // R2 free-running timebase, gap sweep
        rd(4'h8, c0, vl);
        for (int g = 1; g <= 20; g++) begin
            repeat (g) @(negedge clk);
            rd(4'h8, c1, vl);
            chk("R2 timebase gap", (c1 - c0) & 255, g);
            c0 = c1;
        end
        repeat (300) @(negedge clk);
        rd(4'h8, c1, vl);
        chk("R2 timebase wrap", (c1 - c0) & 255, 300 % 256);

        // R3 kick while disabled does not clear the counter
        rd(4'h8, c0, vl);
        wr(4'h0, 4'h4);
        rd(4'h8, c1, vl);
        chk("R3 disabled kick keeps count", (c1 - c0) & 255, 1);
        rd(4'h0, v, vl); chk("R3 disabled kick no flag", v, 0);

        // R10 time word not writable, unmapped reads zero
        wr(4'h8, 4'h0);
        rd(4'h8, c0, vl);
        chk("R10 time write ignored", (c0 - c1) & 255, 1);
        rd(4'hC, v, vl); chk("R10 unmapped", v, 0);

        // kick-offset sweep through the full two-stage timeout
        for (int d = 0; d <= 12; d++) begin
            wr(4'h0, 4'hE);
            wr(4'h4, 4'h1);
            rd(4'h0, v, vl); chk("R11 start clears flags", v, 2);
            repeat (d) @(negedge clk);
            wr(4'h0, 4'h6);
            rd(4'h8, v, vl); chk("R3 kick clears count", v, 0);
            run(IVL, fi, fr, nr, fil, frl);
            chk("R4 irq delay", fi, IVL);
            rd(4'h0, v, vl); chk("R4 flag set", v, 6);
            rd(4'h4, v, vl); chk("R10 enable B bit0", v, 1);
            wr(4'h0, 4'h2);
            rd(4'h0, v, vl); chk("R5 write 0 keeps flag", v, 6);
            chk("R5 irq held", int'(irq), 1);
            wr(4'h0, 4'h6);
            chk("R5 irq cleared", int'(irq), 0);
            rd(4'h0, v, vl); chk("R5 flag cleared", v, 2);
            run(2 * IVL + 13, fi, fr, nr, fil, frl);
            chk("R4 irq after re-kick", fi, IVL);
            chk("R6 reset_req delay", fr, 2 * IVL);
            chk("R6 pulse length", nr, PULSE);
            chk("R6 lock instance delay", frl, 2 * IVL);
            rd(4'h0, v, vl); chk("R7 after pulse ctrl0", v, 8);
            rd(4'h4, v, vl); chk("R7 after pulse ctrl1", v, 0);
            wr(4'h0, 4'h0);
            rd(4'h0, v, vl); chk("R7 write 0 keeps rst status", v, 8);
        end

        // R7 write 1 clears reset status
        wr(4'h0, 4'h8);
        rd(4'h0, v, vl); chk("R7 rst status cleared", v, 0);

        // R8 dual enable and R9 enable-once lock
        wr(4'h0, 4'hE);
        wr(4'h4, 4'h1);
        wr(4'h0, 4'h6);
        wr(4'h0, 4'h0);
        run(IVL - 1, fi, fr, nr, fil, frl);
        chk("R8 still timing on enable B", fi, IVL - 1);
        rd(4'h0, v, vl);
        chk("R8 enable A cleared", v, 4);
        chk("R9 lock keeps enable A", vl, 6);
        wr(4'h0, 4'h4);
        chk("R8 kick with enable B", int'(irq), 0);
        wr(4'h4, 4'h0);
        rd(4'h4, v, vl);
        chk("R8 enable B cleared", v, 0);
        chk("R9 lock keeps enable B", vl, 1);
        run(2 * IVL + 13, fi, fr, nr, fil, frl);
        chk("R8 stopped no irq", fi, -1);
        chk("R8 stopped no reset", fr, -1);
        chk("R9 locked irq", fil, IVL - 1);
        chk("R9 locked reset", frl, 2 * IVL - 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule